// File: doc/BRIEF.md
# Pairwise Address Correlation Prefetcher

This block learns, from a stream of cache miss addresses, which miss tended to come right after which. It keeps a small direct-mapped table keyed by a miss address. Each entry holds a few candidate successor addresses, and each candidate has a two-bit confidence counter. When a miss arrives, the block does two things. First, it trains the entry of the previous miss with the new address as a successor. Second, it looks up the new address's own entry and issues the confident successors as prefetch addresses. This targets pointer-chasing access sequences where no stride exists.

Lookahead is extended by chaining. In each following cycle the strongest prefetch just issued becomes the next lookup key, up to a fixed depth. The chain ends early when a lookup finds no entry or no confident successor. A new miss always takes the lookup port and restarts the chain.

Top module: `corr_prefetch`

## Requirements
- R1: While reset is asserted and after it is released, `pf_valid` is all zero. The first miss after reset produces no prefetch in the following cycle.
- R2: Prefetches for a miss appear in the cycle after the miss is sampled. The lookup reads the table as it stood before that miss's own training. An address that has followed the key often enough appears as a prefetch for that key. Lane k occupies `pf_addr[k*ADDR_W +: ADDR_W]`, and lane 0 is bits `[ADDR_W-1:0]`.
- R3: Only successors with a confidence of at least 2 are issued. A successor seen once (confidence 1) produces no prefetch.
- R4: Issued successors fill lanes contiguously from lane 0 in descending confidence order. Ties go to the lower slot number.
- R5: When the successor being trained is not already present, it replaces the slot with the lowest confidence (lowest slot on a tie) and starts at confidence 1. A present successor has its confidence raised by one, and no successor is stored twice in an entry.
- R6: Confidence saturates at 3 and never wraps, so a successor trained many times keeps being issued.
- R7: The entry index is the low `IDX_W` bits of the address, and the tag is the remaining bits. Training an entry whose tag differs reallocates it to the new tag and clears all of its old successors. A lookup whose tag differs yields no prefetch.
- R8: When no miss arrives, the cycle after a level that issued a valid lane 0 looks up that lane 0 address. It issues that entry's successors as the next level, one level per cycle, up to `DEPTH` levels. After level `DEPTH`, `pf_valid` returns to zero.
- R9: A chained lookup that misses the table yields all-zero `pf_valid` and ends the chain.
- R10: A miss arriving during a chain takes priority. The next output is the lookup of the new miss, not the chain's next level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss address is presented this cycle |
| miss_addr | input | ADDR_W | Miss line address |
| pf_valid | output | BREADTH | Per-lane prefetch valid, lane 0 strongest |
| pf_addr | output | BREADTH*ADDR_W | Per-lane prefetch address, lane k at bits k*ADDR_W upward |

## Verification
A corrupted confidence counter or successor slot surfaces at the ports the next time its key misses. The prefetch then appears too early, too late, in the wrong lane, or not at all, one cycle after that miss. A wrong tag comparison or a missing entry clear surfaces either on a direct lookup of an aliasing address or on the second level of a chain, two cycles after the triggering miss. Chain control faults show as an extra or missing level in the cycles right after a miss, or as a stale level where a new miss should have taken over.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef logic [1:0] conf_t;

  localparam conf_t CONF_INIT = 2'd1;
  localparam conf_t CONF_MIN  = 2'd2;
  localparam conf_t CONF_MAX  = 2'd3;

  function automatic conf_t conf_bump(conf_t c);
    return (c == CONF_MAX) ? c : c + 2'd1;
  endfunction
endpackage

// File: rtl/pcp_train.sv
// Computes the updated successor slots of one table entry for a trained successor.
module pcp_train
  import pcp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BREADTH = 2
) (
  input  logic                      hit,
  input  logic [BREADTH*ADDR_W-1:0] in_sa,
  input  logic [BREADTH*2-1:0]      in_sc,
  input  logic [ADDR_W-1:0]         succ,
  output logic [BREADTH*ADDR_W-1:0] out_sa,
  output logic [BREADTH*2-1:0]      out_sc,
  output logic [BREADTH-1:0]        match
);
  logic [BREADTH*2-1:0] base_sc;

  // A missing or re-tagged entry starts from empty slots (confidence 0 = empty)
  assign base_sc = hit ? in_sc : '0;

  always_comb begin
    for (int i = 0; i < BREADTH; i++)
      match[i] = (base_sc[2*i +: 2] != 2'd0) && (in_sa[i*ADDR_W +: ADDR_W] == succ);
  end

  always_comb begin
    int vic;
    vic    = 0;
    out_sa = in_sa;
    out_sc = base_sc;
    for (int i = 1; i < BREADTH; i++)
      if (base_sc[2*i +: 2] < base_sc[2*vic +: 2]) vic = i;
    if (|match) begin
      for (int i = 0; i < BREADTH; i++)
        if (match[i]) out_sc[2*i +: 2] = conf_bump(base_sc[2*i +: 2]);
    end else begin
      for (int i = 0; i < BREADTH; i++)
        if (i == vic) begin
          out_sa[i*ADDR_W +: ADDR_W] = succ;
          out_sc[2*i +: 2]           = CONF_INIT;
        end
    end
  end
endmodule

// File: rtl/pcp_rank.sv
// Picks confident successors of a looked-up entry and orders them by confidence.
module pcp_rank
  import pcp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BREADTH = 2
) (
  input  logic                      hit,
  input  logic [BREADTH*ADDR_W-1:0] sa,
  input  logic [BREADTH*2-1:0]      sc,
  output logic [BREADTH-1:0]        lane_v,
  output logic [BREADTH*ADDR_W-1:0] lane_a,
  output logic [BREADTH*2-1:0]      lane_c
);
  logic [BREADTH-1:0] qual;

  always_comb begin
    for (int i = 0; i < BREADTH; i++)
      qual[i] = hit && (sc[2*i +: 2] >= CONF_MIN);
  end

  always_comb begin
    int pos;
    lane_v = '0;
    lane_a = '0;
    lane_c = '0;
    for (int i = 0; i < BREADTH; i++) begin
      pos = 0;
      for (int j = 0; j < BREADTH; j++)
        if (qual[j] && (j != i) &&
            ((sc[2*j +: 2] > sc[2*i +: 2]) ||
             ((sc[2*j +: 2] == sc[2*i +: 2]) && (j < i))))
          pos++;
      if (qual[i]) begin
        lane_v[pos]                  = 1'b1;
        lane_a[pos*ADDR_W +: ADDR_W] = sa[i*ADDR_W +: ADDR_W];
        lane_c[2*pos +: 2]           = sc[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/corr_prefetch.sv
module corr_prefetch
  import pcp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 3,
  parameter int BREADTH = 2,
  parameter int DEPTH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  input  logic [ADDR_W-1:0]         miss_addr,
  output logic [BREADTH-1:0]        pf_valid,
  output logic [BREADTH*ADDR_W-1:0] pf_addr
);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LVL_W   = $clog2(DEPTH + 1);

  // Table storage
  logic [ENTRIES-1:0]        ent_v_q;
  logic [TAG_W-1:0]          ent_tag_q [ENTRIES];
  logic [BREADTH*ADDR_W-1:0] ent_sa_q  [ENTRIES];
  logic [BREADTH*2-1:0]      ent_sc_q  [ENTRIES];

  logic [ADDR_W-1:0]         prev_q;
  logic                      prev_v_q;
  logic [BREADTH-1:0]        pf_v_q, pf_v_d;
  logic [BREADTH*ADDR_W-1:0] pf_a_q;
  logic [LVL_W-1:0]          lvl_q, lvl_d;
  logic                      issue;

  // Training port: entry of the previous miss
  logic [IDX_W-1:0]          t_idx;
  logic [TAG_W-1:0]          t_tag;
  logic                      t_hit, t_we;
  logic [BREADTH*ADDR_W-1:0] tr_sa;
  logic [BREADTH*2-1:0]      tr_sc;
  logic [BREADTH-1:0]        tr_match;

  assign t_idx = prev_q[IDX_W-1:0];
  assign t_tag = prev_q[ADDR_W-1:IDX_W];
  assign t_hit = ent_v_q[t_idx] && (ent_tag_q[t_idx] == t_tag);
  assign t_we  = miss_valid && prev_v_q;

  pcp_train #(.ADDR_W(ADDR_W), .BREADTH(BREADTH)) u_train (
    .hit(t_hit), .in_sa(ent_sa_q[t_idx]), .in_sc(ent_sc_q[t_idx]),
    .succ(miss_addr), .out_sa(tr_sa), .out_sc(tr_sc), .match(tr_match)
  );

  // Lookup port: a new miss, otherwise the strongest lane of the last level
  logic [ADDR_W-1:0]         l_key;
  logic [IDX_W-1:0]          l_idx;
  logic                      l_hit;
  logic [BREADTH-1:0]        lane_v;
  logic [BREADTH*ADDR_W-1:0] lane_a;
  logic [BREADTH*2-1:0]      lane_c;

  assign l_key = miss_valid ? miss_addr : pf_a_q[ADDR_W-1:0];
  assign l_idx = l_key[IDX_W-1:0];
  assign l_hit = ent_v_q[l_idx] && (ent_tag_q[l_idx] == l_key[ADDR_W-1:IDX_W]);

  pcp_rank #(.ADDR_W(ADDR_W), .BREADTH(BREADTH)) u_rank (
    .hit(l_hit), .sa(ent_sa_q[l_idx]), .sc(ent_sc_q[l_idx]),
    .lane_v(lane_v), .lane_a(lane_a), .lane_c(lane_c)
  );

  // Next-state logic for the chain
  always_comb begin
    issue  = miss_valid ||
             ((lvl_q != '0) && (lvl_q < LVL_W'(DEPTH)) && pf_v_q[0]);
    pf_v_d = issue ? lane_v : '0;
    if (miss_valid)  lvl_d = LVL_W'(1);
    else if (issue)  lvl_d = lvl_q + LVL_W'(1);
    else             lvl_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_v_q   <= '0;
      lvl_q    <= '0;
      prev_v_q <= 1'b0;
    end else begin
      pf_v_q <= pf_v_d;
      lvl_q  <= lvl_d;
      if (miss_valid) prev_v_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (issue)      pf_a_q <= lane_a;
    if (miss_valid) prev_q <= miss_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v_q <= '0;
      for (int e = 0; e < ENTRIES; e++) ent_sc_q[e] <= '0;
    end else if (t_we) begin
      ent_v_q[t_idx]  <= 1'b1;
      ent_sc_q[t_idx] <= tr_sc;
    end
  end

  always_ff @(posedge clk) begin
    if (t_we) begin
      ent_tag_q[t_idx] <= t_tag;
      ent_sa_q[t_idx]  <= tr_sa;
    end
  end

  assign pf_valid = pf_v_q;
  assign pf_addr  = pf_a_q;

  // Assertions
  assert_first_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !prev_v_q) |=> (pf_valid == '0));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_valid && (lvl_q == LVL_W'(DEPTH))) |=> (pf_valid == '0));

  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    t_we |-> ($countones(tr_match) <= 1));

  genvar g;
  generate
    for (g = 0; g < BREADTH; g++) begin : g_lane_chk
      assert_lane_conf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_v[g] |-> (lane_c[2*g +: 2] >= CONF_MIN));
      assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_we && tr_match[g]) |-> (tr_sc[2*g +: 2] != 2'd0));
      if (g > 0) begin : g_ord
        assert_lane_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
          lane_v[g] |-> (lane_v[g-1] && (lane_c[2*(g-1) +: 2] >= lane_c[2*g +: 2])));
      end
    end
  endgenerate
endmodule

// File: tb/sim_corr_prefetch.sv
module sim_corr_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          miss_valid;
  logic [AW-1:0] miss_addr;
  logic [1:0]    pf_valid;
  logic [2*AW-1:0] pf_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [1:0]  cap_v [3];
  logic [31:0] cap_a [3];

  localparam logic [15:0] D  = 16'h0011, E  = 16'h0022, X  = 16'h002A, Y = 16'h0033;
  localparam logic [15:0] K  = 16'h0031, S1 = 16'h0042, S2 = 16'h0053, S3 = 16'h0064;
  localparam logic [15:0] A  = 16'h0019, F  = 16'h0045;

  corr_prefetch #(.ADDR_W(16), .IDX_W(3), .BREADTH(2), .DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input string what,
                       input logic [1:0] gv, input logic [31:0] ga,
                       input logic [1:0] ev, input logic [31:0] ea);
    n_checks++;
    if ((gv !== ev) || (ev[0] && ga[15:0] !== ea[15:0]) ||
        (ev[1] && ga[31:16] !== ea[31:16])) begin
      n_fails++;
      $display("FAIL %s %s: valid=%b addr=%h expected valid=%b addr=%h",
               req, what, gv, ga, ev, ea);
    end
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    miss_valid = 1'b0;
    miss_addr  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Present one miss and capture the next three output cycles
  task automatic fire(input logic [15:0] a);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    cap_v[0] = pf_valid; cap_a[0] = pf_addr;
    miss_valid = 1'b0;
    @(negedge clk);
    cap_v[1] = pf_valid; cap_a[1] = pf_addr;
    @(negedge clk);
    cap_v[2] = pf_valid; cap_a[2] = pf_addr;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    miss_valid = 1'b0;
    miss_addr = '0;
    @(negedge clk);
    check("R1", "during reset", pf_valid, pf_addr, 2'b00, 32'h0);
    do_reset();
    check("R1", "after reset", pf_valid, pf_addr, 2'b00, 32'h0);
    fire(16'h0010);
    check("R1", "first miss", cap_v[0], cap_a[0], 2'b00, 32'h0);
  endtask

  task automatic t_learn();
    do_reset();
    fire(D); fire(E); fire(D);
    check("R3", "succ at conf 1", cap_v[0], cap_a[0], 2'b00, 32'h0);
    fire(E);
    check("R3", "reverse link conf 1", cap_v[0], cap_a[0], 2'b00, 32'h0);
    fire(D);
    check("R2", "learned successor", cap_v[0], cap_a[0], 2'b01, {16'h0, E});
    check("R8", "chain level 2", cap_v[1], cap_a[1], 2'b01, {16'h0, D});
    check("R8", "depth limit", cap_v[2], cap_a[2], 2'b00, 32'h0);
  endtask

  task automatic t_order();
    do_reset();
    fire(K); fire(S1); fire(K); fire(S1);
    fire(K); fire(S2); fire(K); fire(S2); fire(K); fire(S2);
    fire(K);
    check("R4", "descending order", cap_v[0], cap_a[0], 2'b11, {S1, S2});
    fire(S3); fire(K);
    check("R5", "lowest replaced", cap_v[0], cap_a[0], 2'b01, {16'h0, S2});
    fire(S3); fire(K);
    check("R5", "new succ grows", cap_v[0], cap_a[0], 2'b11, {S3, S2});
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      fire(D); fire(E);
    end
    fire(D);
    check("R6", "saturated conf", cap_v[0], cap_a[0], 2'b01, {16'h0, E});
  endtask

  task automatic t_retag();
    do_reset();
    fire(D); fire(E); fire(D); fire(E);
    fire(A); fire(E);
    fire(D);
    check("R7", "old tag gone", cap_v[0], cap_a[0], 2'b00, 32'h0);
    fire(A);
    check("R7", "slots cleared", cap_v[0], cap_a[0], 2'b00, 32'h0);
  endtask

  task automatic t_chain_miss();
    do_reset();
    fire(D); fire(E); fire(D); fire(E); fire(D); fire(E);
    fire(X); fire(Y);
    fire(D);
    check("R9", "level 1", cap_v[0], cap_a[0], 2'b01, {16'h0, E});
    check("R9", "chain table miss", cap_v[1], cap_a[1], 2'b00, 32'h0);
  endtask

  task automatic t_preempt();
    logic [1:0]  v0, v1;
    logic [31:0] a0, a1;
    do_reset();
    fire(D); fire(E); fire(D); fire(E); fire(D); fire(E);
    miss_valid = 1'b1;
    miss_addr  = D;
    @(negedge clk);
    v0 = pf_valid; a0 = pf_addr;
    miss_addr = F;
    @(negedge clk);
    v1 = pf_valid; a1 = pf_addr;
    miss_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", "first miss", v0, a0, 2'b01, {16'h0, E});
    check("R10", "new miss wins", v1, a1, 2'b00, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_learn();
    t_order();
    t_saturate();
    t_retag();
    t_chain_miss();
    t_preempt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule